// File: doc/BRIEF.md
# Core Event Priority Controller

This block sits beside a processor core and decides which of sixteen event levels the core should service next. Requests arrive as pulses on a per-level input bus and are held in a pending latch. Each cycle the controller qualifies the pending set with an enable mask, finds the most urgent qualified level and compares it with the levels already being serviced. If the new level is more urgent than every level in service, the controller issues a one-cycle dispatch strobe carrying the level number and the handler address for that level.

Level 0 is the most urgent and level 15 the least. The five most urgent levels always pass the mask. The two most urgent levels have handler addresses fixed by parameters. The remaining levels take their handler addresses from a small writable table. A return strobe from the core retires the most urgent level in service, which lets lower levels through again. A simple register port gives access to the mask, the pending latch, the in-service set and the handler table.

Top module: `evt_core_ctrl`

## Requirements
- R1: After reset the pending latch and the in-service set read 0, the mask reads 0x001F and no dispatch strobe is raised.
- R2: The mask register sits at address 0. Its low five bits always read 1 whatever is written, and the other bits read back as written.
- R3: A high bit on `evt_req` sets that level's bit in the pending latch at address 1. A disabled level stays pending and is not dispatched.
- R4: Writing to address 1 clears exactly the pending bits that are 1 in the written data and leaves the other pending bits alone.
- R5: Among the pending levels that are enabled, the lowest-numbered level is dispatched first. A level counts as enabled when its mask bit is 1 or its number is below 5.
- R6: A dispatch raises `take_valid` for one cycle, two clock edges after the request pulse, with `take_level` and that level's handler address on `take_vector`. It also clears the level's pending bit and sets its bit in the in-service set at address 2.
- R7: A pending level is dispatched only if its number is lower than every level currently in service. A less urgent or equal level waits, still pending.
- R8: A high `rti` for one cycle clears the lowest-numbered bit of the in-service set.
- R9: Handler addresses are read and written at address 16+level. Levels 0 and 1 always return the parameters `VEC_EMU` and `VEC_RST`, and writes to them are ignored. Levels 2 to 15 read back what was written.
- R10: With the mask written to 0, no level from 5 to 15 is dispatched, but levels 0 to 4 still are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_req | input | 16 | Per-level event request pulses |
| rti | input | 1 | Return strobe: retire the most urgent in-service level |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 5 | Register address (0 mask, 1 pending, 2 in-service, 16+n handler n) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| take_valid | output | 1 | One-cycle dispatch strobe |
| take_level | output | 4 | Level being dispatched |
| take_vector | output | 32 | Handler address of the dispatched level |

## Verification
The bench builds the block with its defaults: sixteen levels, 32-bit handler addresses and five unmaskable levels. It overrides the two fixed handler addresses with values it knows, so that the fixed entries, the unmaskable range and the full register address space can all be reached. Those defaults allow a nested dispatch of a more urgent level on top of a less urgent one, and a return that uncovers a waiting level. They also allow simultaneous requests, mask-blocked levels held pending, and dispatches of levels 0 and 1 with their fixed addresses.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    // register selected by the low address half
    typedef enum logic [1:0] {
        SEL_MASK    = 2'd0,
        SEL_PENDING = 2'd1,
        SEL_SERVICE = 2'd2,
        SEL_NONE    = 2'd3
    } ecc_reg_e;

    localparam int FIXED_VECTORS = 2;

endpackage

// File: rtl/ecc_first_set.sv
module ecc_first_set #(
    parameter int N = 16,
    localparam int LVL_W = $clog2(N)
) (
    input  logic [N-1:0]     bits,
    output logic             found,
    output logic [LVL_W-1:0] index,
    output logic [N-1:0]     onehot
);

    // scan from the top down so the lowest set index wins
    always_comb begin
        found  = 1'b0;
        index  = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found     = 1'b1;
                index     = LVL_W'(i);
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ecc_vec_table.sv
module ecc_vec_table import ecc_pkg::*; #(
    parameter int              N       = 16,
    parameter int              VEC_W   = 32,
    parameter logic [VEC_W-1:0] VEC_EMU = 32'h0000_0100,
    parameter logic [VEC_W-1:0] VEC_RST = 32'h0000_0200,
    localparam int             LVL_W   = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_idx,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [LVL_W-1:0] rd_idx_a,
    output logic [VEC_W-1:0] rd_data_a,
    input  logic [LVL_W-1:0] rd_idx_b,
    output logic [VEC_W-1:0] rd_data_b
);

    logic [VEC_W-1:0] entry [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        if (g == 0) begin : g_emu
            assign entry[g] = VEC_EMU;
        end else if (g == 1) begin : g_rst
            assign entry[g] = VEC_RST;
        end else begin : g_prog
            logic [VEC_W-1:0] val_d, val_q;
            always_comb begin
                val_d = val_q;
                if (wr_en && wr_idx == LVL_W'(g)) begin
                    val_d = wr_data;
                end
            end
            always_ff @(posedge clk) begin
                if (!rst_n) val_q <= '0;
                else        val_q <= val_d;
            end
            assign entry[g] = val_q;
        end
    end

    assign rd_data_a = entry[rd_idx_a];
    assign rd_data_b = entry[rd_idx_b];

endmodule

// File: rtl/evt_core_ctrl.sv
module evt_core_ctrl import ecc_pkg::*; #(
    parameter int               N          = 16,
    parameter int               VEC_W      = 32,
    parameter int               UNMASKABLE = 5,
    parameter logic [VEC_W-1:0] VEC_EMU    = 32'h0000_0100,
    parameter logic [VEC_W-1:0] VEC_RST    = 32'h0000_0200,
    localparam int              LVL_W      = $clog2(N),
    localparam int              ADDR_W     = LVL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      evt_req,
    input  logic              rti,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [VEC_W-1:0]  reg_wdata,
    output logic [VEC_W-1:0]  reg_rdata,
    output logic              take_valid,
    output logic [LVL_W-1:0]  take_level,
    output logic [VEC_W-1:0]  take_vector
);

    localparam logic [N-1:0] FORCE_ON = ~({N{1'b1}} << UNMASKABLE);

    typedef struct packed {
        logic [N-1:0]     mask;
        logic [N-1:0]     pending;
        logic [N-1:0]     service;
        logic             valid;
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
    } state_t;

    state_t s_d, s_q;

    // register port decode
    logic             is_vec;
    logic [LVL_W-1:0] vec_idx;
    ecc_reg_e         sel;

    always_comb begin
        is_vec  = reg_addr[ADDR_W-1];
        vec_idx = reg_addr[LVL_W-1:0];
        sel     = SEL_NONE;
        if (!is_vec) begin
            case (vec_idx)
                LVL_W'(0): sel = SEL_MASK;
                LVL_W'(1): sel = SEL_PENDING;
                LVL_W'(2): sel = SEL_SERVICE;
                default:   sel = SEL_NONE;
            endcase
        end
    end

    // arbitration
    logic [N-1:0]     eligible;
    logic             pend_found, serv_found;
    logic [LVL_W-1:0] pend_idx, serv_idx;
    logic [N-1:0]     pend_oh, serv_oh;
    logic             take;
    logic [VEC_W-1:0] vec_rd, vec_take;
    logic [N-1:0]     service_q;

    assign eligible  = s_q.pending & (s_q.mask | FORCE_ON);
    assign service_q = s_q.service;

    ecc_first_set #(.N(N)) u_pick_pend (
        .bits   (eligible),
        .found  (pend_found),
        .index  (pend_idx),
        .onehot (pend_oh)
    );

    ecc_first_set #(.N(N)) u_pick_serv (
        .bits   (s_q.service),
        .found  (serv_found),
        .index  (serv_idx),
        .onehot (serv_oh)
    );

    assign take = pend_found && (!serv_found || (pend_idx < serv_idx));

    ecc_vec_table #(
        .N       (N),
        .VEC_W   (VEC_W),
        .VEC_EMU (VEC_EMU),
        .VEC_RST (VEC_RST)
    ) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && is_vec),
        .wr_idx    (vec_idx),
        .wr_data   (reg_wdata),
        .rd_idx_a  (vec_idx),
        .rd_data_a (vec_rd),
        .rd_idx_b  (pend_idx),
        .rd_data_b (vec_take)
    );

    // next state
    always_comb begin
        logic [N-1:0] clr_w;
        logic [N-1:0] take_oh;
        logic [N-1:0] rti_oh;

        s_d       = s_q;
        s_d.valid = 1'b0;

        clr_w   = (reg_wr && sel == SEL_PENDING) ? reg_wdata[N-1:0] : '0;
        take_oh = take ? pend_oh : '0;
        rti_oh  = rti ? serv_oh : '0;

        if (reg_wr && sel == SEL_MASK) begin
            s_d.mask = reg_wdata[N-1:0];
        end

        s_d.pending = (s_q.pending & ~clr_w & ~take_oh) | evt_req;
        s_d.service = (s_q.service & ~rti_oh) | take_oh;

        if (take) begin
            s_d.valid  = 1'b1;
            s_d.level  = pend_idx;
            s_d.vector = vec_take;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // read data
    always_comb begin
        reg_rdata = '0;
        if (is_vec) begin
            reg_rdata = vec_rd;
        end else begin
            case (sel)
                SEL_MASK:    reg_rdata = VEC_W'(s_q.mask | FORCE_ON);
                SEL_PENDING: reg_rdata = VEC_W'(s_q.pending);
                SEL_SERVICE: reg_rdata = VEC_W'(s_q.service);
                default:     reg_rdata = '0;
            endcase
        end
    end

    assign take_valid  = s_q.valid;
    assign take_level  = s_q.level;
    assign take_vector = s_q.vector;

endmodule

// File: rtl/ecc_checker.sv
module ecc_checker #(
    parameter int               N       = 16,
    parameter int               VEC_W   = 32,
    parameter logic [VEC_W-1:0] VEC_EMU = 32'h0000_0100,
    parameter logic [VEC_W-1:0] VEC_RST = 32'h0000_0200,
    localparam int              LVL_W   = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rti,
    input logic             take_valid,
    input logic [LVL_W-1:0] take_level,
    input logic [VEC_W-1:0] take_vector,
    input logic [N-1:0]     service
);

    logic [N-1:0] at_or_above;
    always_comb begin
        for (int i = 0; i < N; i++) begin
            at_or_above[i] = (LVL_W'(i) <= take_level);
        end
    end

    // R6: a dispatched level is marked in service
    a_r6_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> service[take_level]);

    // R7: nothing at or above the dispatched number was in service before
    a_r7_nest_higher: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> (($past(service) & at_or_above) == '0));

    // R8: a return retires exactly one level (a simultaneous dispatch adds one)
    a_r8_rti_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && (service != '0)) |=>
            ($countones(service) + 1 == $past($countones(service)) + (take_valid ? 1 : 0)));

    // R9: fixed handler addresses for the two most urgent levels
    a_r9_emu_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && take_level == LVL_W'(0)) |-> take_vector == VEC_EMU);

    a_r9_rst_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && take_level == LVL_W'(1)) |-> take_vector == VEC_RST);

endmodule

bind evt_core_ctrl ecc_checker #(
    .N       (N),
    .VEC_W   (VEC_W),
    .VEC_EMU (VEC_EMU),
    .VEC_RST (VEC_RST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rti         (rti),
    .take_valid  (take_valid),
    .take_level  (take_level),
    .take_vector (take_vector),
    .service     (service_q)
);

// File: tb/evt_core_ctrl_test.sv
`timescale 1ns/1ps
module evt_core_ctrl_test;

    localparam int          N       = 16;
    localparam int          VEC_W   = 32;
    localparam logic [31:0] EXP_EMU = 32'h0000_0A00;
    localparam logic [31:0] EXP_RST = 32'h0000_0B00;
    localparam logic [4:0]  A_MASK  = 5'd0;
    localparam logic [4:0]  A_PEND  = 5'd1;
    localparam logic [4:0]  A_SERV  = 5'd2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      evt_req = '0;
    logic              rti = 1'b0;
    logic              reg_wr = 1'b0;
    logic [4:0]        reg_addr = '0;
    logic [VEC_W-1:0]  reg_wdata = '0;
    logic [VEC_W-1:0]  reg_rdata;
    logic              take_valid;
    logic [3:0]        take_level;
    logic [VEC_W-1:0]  take_vector;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    evt_core_ctrl #(
        .N       (N),
        .VEC_W   (VEC_W),
        .VEC_EMU (EXP_EMU),
        .VEC_RST (EXP_RST)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_req     (evt_req),
        .rti         (rti),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .take_valid  (take_valid),
        .take_level  (take_level),
        .take_vector (take_vector)
    );

    function automatic logic [31:0] exp_vec(int lvl);
        if (lvl == 0) return EXP_EMU;
        if (lvl == 1) return EXP_RST;
        return 32'h8000_0000 + 32'(lvl * 16);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [4:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic pulse(logic [N-1:0] b);
        evt_req = b;
        @(negedge clk);
        evt_req = '0;
    endtask

    task automatic ret();
        rti = 1'b1;
        @(negedge clk);
        rti = 1'b0;
    endtask

    task automatic expect_take(int lvl);
        exp_q.push_back(lvl);
    endtask

    task automatic drained(string req);
        check(req, 32'(exp_q.size()), 32'd0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && take_valid && !finished) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected dispatch", 32'(take_level), 32'hFFFF_FFFF);
            end else begin
                int lvl;
                lvl = exp_q.pop_front();
                check("R6 level", 32'(take_level), 32'(lvl));
                check("R6 vector", take_vector, exp_vec(lvl));
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        check("R1 strobe", 32'(take_valid), 32'd0);
        rd_check("R1 mask", A_MASK, 32'h0000_001F);
        rd_check("R1 pending", A_PEND, 32'h0);
        rd_check("R1 service", A_SERV, 32'h0);

        // R9 handler table
        for (int i = 0; i < N; i++) wr(5'(16 + i), 32'h8000_0000 + 32'(i * 16));
        rd_check("R9 fixed emu", 5'd16, EXP_EMU);
        rd_check("R9 fixed rst", 5'd17, EXP_RST);
        rd_check("R9 level2", 5'd18, exp_vec(2));
        rd_check("R9 level15", 5'd31, exp_vec(15));

        // R2 mask low bits forced
        wr(A_MASK, 32'h0000_FFFF);
        rd_check("R2 all ones", A_MASK, 32'h0000_FFFF);
        wr(A_MASK, 32'h0000_0A80);
        rd_check("R2 pattern", A_MASK, 32'h0000_0A9F);
        wr(A_MASK, 32'h0);
        rd_check("R2 zero", A_MASK, 32'h0000_001F);

        // R10 / R3 masked level stays pending
        pulse(16'h0200);
        tick(3);
        drained("R10 masked not taken");
        rd_check("R3 latched", A_PEND, 32'h0000_0200);

        // R10 unmaskable levels still dispatched, R6 side effects
        expect_take(3);
        pulse(16'h0008);
        tick(3);
        drained("R10 unmaskable taken");
        rd_check("R6 pending cleared", A_PEND, 32'h0000_0200);
        rd_check("R6 service set", A_SERV, 32'h0000_0008);
        ret();
        rd_check("R8 service cleared", A_SERV, 32'h0);

        // fixed vectors through dispatch
        expect_take(0);
        pulse(16'h0001);
        tick(3);
        ret();
        expect_take(1);
        pulse(16'h0002);
        tick(3);
        ret();
        drained("R9 fixed dispatch");

        // R4 write-one-to-clear
        wr(A_PEND, 32'h0000_0200);
        rd_check("R4 cleared", A_PEND, 32'h0);
        wr(A_MASK, 32'h0000_FFFF);
        tick(3);
        drained("R4 nothing left");

        // R5 priority among simultaneous requests, R7 blocking
        expect_take(8);
        pulse(16'h1100);
        tick(3);
        rd_check("R5 service", A_SERV, 32'h0000_0100);
        rd_check("R7 less urgent waits", A_PEND, 32'h0000_1000);
        drained("R7 no second take");
        expect_take(12);
        ret();
        tick(3);
        rd_check("R8 uncovered level", A_SERV, 32'h0000_1000);
        ret();

        // R7 nesting
        expect_take(10);
        pulse(16'h0400);
        tick(3);
        expect_take(6);
        pulse(16'h0040);
        tick(3);
        rd_check("R7 nested", A_SERV, 32'h0000_0440);
        pulse(16'h0800);
        tick(3);
        rd_check("R7 blocked pending", A_PEND, 32'h0000_0800);
        drained("R7 blocked");
        ret();
        tick(2);
        rd_check("R8 most urgent retired", A_SERV, 32'h0000_0400);
        drained("R8 still blocked");
        expect_take(11);
        ret();
        tick(3);
        rd_check("R8 after second rti", A_SERV, 32'h0000_0800);
        ret();
        rd_check("R8 empty", A_SERV, 32'h0);

        // R5 masked level skipped in favour of enabled one
        wr(A_MASK, 32'h0000_FEFF);
        expect_take(14);
        pulse(16'h4100);
        tick(3);
        rd_check("R5 masked kept", A_PEND, 32'h0000_0100);
        ret();
        wr(A_PEND, 32'h0000_0100);
        tick(3);
        drained("R5 final");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule